// File: doc/BRIEF.md
# Serial NAND Feature and Status Register Model

This block models the register file that a serial NAND flash device exposes through its feature-access commands. An SPI front end decodes each incoming command and hands this block one opcode strobe together with the feature address and the byte to be written. The block keeps the protection and configuration bytes and two status bytes. It runs the busy flag and the write-enable latch, and it records the program-fail flag, the erase-fail flag and the two ECC severity fields. It answers feature reads with a registered byte.

The flash array is not modelled. The time an array operation takes comes from a cycle count that is loaded when the operation starts. The result of the operation comes from inputs that are sampled in the cycle the count runs out: a fail indication, which also covers an attempt to touch a locked region, a coarse two-bit ECC outcome and a two-bit detail field. The block is used as the device side of a controller testbench, or as a stand-in for the flash in system simulations.

Top module: `snf_status_model`

## Requirements
- R1: After reset, every register, the busy output and the read data are all zero.
- R2: A feature read (opcode 0x0F) is accepted at any time. In the next cycle `rd_data` holds the addressed byte. Address 0xA0 is protection and 0xB0 is configuration. Address 0xC0 is status with bit0 busy, bit1 write-enable latch, bit2 erase fail, bit3 program fail, bits 5:4 ECC outcome and bits 7:6 zero. Address 0xF0 carries the ECC detail in bits 5:4 and zero elsewhere. Any other address reads 0.
- R3: A feature write (opcode 0x1F) while idle stores bits 7:1 of the data at 0xA0, with bit0 reading 0. At 0xB0 it stores bit4 (ECC enable) and bit0 (quad enable), and the other bits read 0. Writes to 0xC0, 0xF0 or any other address change nothing.
- R4: While idle, opcode 0x06 sets the write-enable latch and opcode 0x04 clears it.
- R5: Program execute (0x10) and block erase (0xD8) issued while the latch is 0 are ignored: busy stays 0 and no flag changes.
- R6: An accepted program execute, block erase, page read (0x13) or reset (0xFF) raises busy in the next cycle. Busy then stays high for `busy_cycles` cycles, or for 1 cycle when `busy_cycles` is 0.
- R7: While busy, every opcode other than 0x0F and 0xFF is ignored.
- R8: Program execute clears the program-fail flag when it is accepted. At completion the flag takes the value of `op_fail` and the write-enable latch clears.
- R9: Block erase clears the erase-fail flag when it is accepted. At completion the flag takes the value of `op_fail` and the write-enable latch clears.
- R10: When a page read completes with ECC enabled, the ECC outcome takes `ecc_result`. The detail field takes `ecc_detail` if the outcome is 01 and 0 otherwise. With ECC disabled, both fields become 0.
- R11: Reset (0xFF) is accepted even while busy. It clears the latch, both fail flags and both ECC fields, and it abandons the pending operation, whose result is never applied. Protection and configuration keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | One-cycle strobe for a decoded opcode |
| op_code | input | 8 | Decoded command opcode |
| feat_addr | input | 8 | Feature address for reads and writes |
| feat_wdata | input | 8 | Feature write data |
| busy_cycles | input | CNT_W | Duration of the array operation being started |
| op_fail | input | 1 | Failure result, sampled at completion |
| ecc_result | input | 2 | Coarse ECC outcome, sampled at page-read completion |
| ecc_detail | input | 2 | ECC detail, sampled at page-read completion |
| rd_data | output | 8 | Registered feature read data |
| busy | output | 1 | Operation in progress |

## Verification
A wrong internal flag does not show up on its own. It reaches the ports only when it is read: at the next feature read of 0xC0 or 0xF0, or one cycle later when busy fails to rise because the latch was wrong. For that reason the bench compares `busy` and `rd_data` with a behavioural model on every cycle, and it reads the status bytes during and after each operation. A timer that is off by one shows up as a busy length that differs from `busy_cycles` at the falling edge. A pending-operation record that is wrong shows up as results applied on the wrong kind of completion, or applied after a reset that should have abandoned them.

// File: rtl/snf_pkg.sv
package snf_pkg;
  localparam logic [7:0] ADDR_PROT  = 8'hA0;
  localparam logic [7:0] ADDR_CFG   = 8'hB0;
  localparam logic [7:0] ADDR_STAT  = 8'hC0;
  localparam logic [7:0] ADDR_STAT2 = 8'hF0;

  localparam logic [7:0] OPC_WREN   = 8'h06;
  localparam logic [7:0] OPC_WRDI   = 8'h04;
  localparam logic [7:0] OPC_GET    = 8'h0F;
  localparam logic [7:0] OPC_SET    = 8'h1F;
  localparam logic [7:0] OPC_PREAD  = 8'h13;
  localparam logic [7:0] OPC_PEXEC  = 8'h10;
  localparam logic [7:0] OPC_ERASE  = 8'hD8;
  localparam logic [7:0] OPC_RESET  = 8'hFF;

  localparam logic [7:0] PROT_KEEP  = 8'hFE;
  localparam logic [7:0] CFG_KEEP   = 8'h11;
  localparam int         CFG_ECC_BIT = 4;

  typedef enum logic [2:0] {
    AOP_NONE, AOP_PROG, AOP_ERASE, AOP_READ, AOP_RST
  } arr_op_e;
endpackage

// File: rtl/snf_busy_timer.sv
module snf_busy_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] load,
  output logic             busy,
  output logic             done
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;

  assign done = busy && (cnt == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= (load == '0) ? ONE : load;
    end else if (done) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      cnt  <= cnt - ONE;
    end
  end

  // R6: busy holds until the count runs out
  p_busy_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && !done && !start) |=> busy);
  // R6: busy only falls right after a completion
  p_busy_drop_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(done));
endmodule

// File: rtl/snf_status_flags.sv
module snf_status_flags
  import snf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  arr_op_e    start_op,
  input  logic       wren,
  input  logic       wrdi,
  input  logic       done,
  input  logic       op_fail,
  input  logic       ecc_en,
  input  logic [1:0] ecc_in,
  input  logic [1:0] ecc_fine_in,
  output logic       wel,
  output logic       p_fail,
  output logic       e_fail,
  output logic [1:0] ecc,
  output logic [1:0] ecc_fine
);
  arr_op_e cur_op;

  always_ff @(posedge clk) begin
    if (rst) begin
      wel      <= 1'b0;
      p_fail   <= 1'b0;
      e_fail   <= 1'b0;
      ecc      <= 2'b00;
      ecc_fine <= 2'b00;
      cur_op   <= AOP_NONE;
    end else begin
      if (done) begin
        case (cur_op)
          AOP_PROG: begin
            p_fail <= op_fail;
            wel    <= 1'b0;
          end
          AOP_ERASE: begin
            e_fail <= op_fail;
            wel    <= 1'b0;
          end
          AOP_READ: begin
            if (ecc_en) begin
              ecc      <= ecc_in;
              ecc_fine <= (ecc_in == 2'b01) ? ecc_fine_in : 2'b00;
            end else begin
              ecc      <= 2'b00;
              ecc_fine <= 2'b00;
            end
          end
          default: ;
        endcase
        cur_op <= AOP_NONE;
      end
      if (wren) wel <= 1'b1;
      if (wrdi) wel <= 1'b0;
      if (start) begin
        cur_op <= start_op;
        case (start_op)
          AOP_PROG:  p_fail <= 1'b0;
          AOP_ERASE: e_fail <= 1'b0;
          AOP_RST: begin
            wel      <= 1'b0;
            p_fail   <= 1'b0;
            e_fail   <= 1'b0;
            ecc      <= 2'b00;
            ecc_fine <= 2'b00;
          end
          default: ;
        endcase
      end
    end
  end

  // R10: detail field only meaningful for the corrected outcome
  p_fine_only_corr_r10: assert property (@(posedge clk) disable iff (rst)
    (ecc != 2'b01) |-> (ecc_fine == 2'b00));
  // R8 / R9: latch drops after program or erase completes
  p_wel_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (done && (cur_op == AOP_PROG || cur_op == AOP_ERASE)) |=> !wel);
  // R11: reset start leaves all flags clear
  p_rst_clear_r11: assert property (@(posedge clk) disable iff (rst)
    (start && start_op == AOP_RST) |=> (!wel && !p_fail && !e_fail && ecc == 2'b00));
endmodule

// File: rtl/snf_feature_regs.sv
module snf_feature_regs
  import snf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  input  logic [7:0] stat0,
  input  logic [7:0] stat1,
  output logic [7:0] prot,
  output logic [7:0] cfg,
  output logic [7:0] rd_data
);
  logic [7:0] sel;

  always_comb begin
    case (addr)
      ADDR_PROT:  sel = prot;
      ADDR_CFG:   sel = cfg;
      ADDR_STAT:  sel = stat0;
      ADDR_STAT2: sel = stat1;
      default:    sel = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prot    <= 8'h00;
      cfg     <= 8'h00;
      rd_data <= 8'h00;
    end else begin
      if (wr_en && addr == ADDR_PROT) prot <= wdata & PROT_KEEP;
      if (wr_en && addr == ADDR_CFG)  cfg  <= wdata & CFG_KEEP;
      if (rd_en) rd_data <= sel;
    end
  end

  // R2: reserved status bits read as zero
  p_reserved_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_STAT) |=> (rd_data[7:6] == 2'b00));
  // R2: unmapped addresses read zero
  p_unmapped_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr != ADDR_PROT && addr != ADDR_CFG && addr != ADDR_STAT
     && addr != ADDR_STAT2) |=> (rd_data == 8'h00));
  // R3: protection bit0 never stored
  p_prot_bit0_r3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (prot[0] == 1'b0));
endmodule

// File: rtl/snf_status_model.sv
module snf_status_model
  import snf_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [7:0]       op_code,
  input  logic [7:0]       feat_addr,
  input  logic [7:0]       feat_wdata,
  input  logic [CNT_W-1:0] busy_cycles,
  input  logic             op_fail,
  input  logic [1:0]       ecc_result,
  input  logic [1:0]       ecc_detail,
  output logic [7:0]       rd_data,
  output logic             busy
);
  logic       oip, done;
  logic       wel, p_fail, e_fail;
  logic [1:0] ecc, ecc_fine;
  logic [7:0] prot, cfg;
  logic [7:0] stat0, stat1;

  logic    idle_cmd, is_get, is_rst;
  logic    do_wren, do_wrdi, do_set;
  logic    go_prog, go_erase, go_read, start;
  arr_op_e start_op;

  assign idle_cmd = op_valid && !oip;
  assign is_get   = op_valid && (op_code == OPC_GET);
  assign is_rst   = op_valid && (op_code == OPC_RESET);
  assign do_wren  = idle_cmd && (op_code == OPC_WREN);
  assign do_wrdi  = idle_cmd && (op_code == OPC_WRDI);
  assign do_set   = idle_cmd && (op_code == OPC_SET);
  assign go_prog  = idle_cmd && (op_code == OPC_PEXEC) && wel;
  assign go_erase = idle_cmd && (op_code == OPC_ERASE) && wel;
  assign go_read  = idle_cmd && (op_code == OPC_PREAD);
  assign start    = go_prog || go_erase || go_read || is_rst;

  always_comb begin
    if (is_rst)        start_op = AOP_RST;
    else if (go_prog)  start_op = AOP_PROG;
    else if (go_erase) start_op = AOP_ERASE;
    else if (go_read)  start_op = AOP_READ;
    else               start_op = AOP_NONE;
  end

  assign stat0 = {2'b00, ecc, p_fail, e_fail, wel, oip};
  assign stat1 = {2'b00, ecc_fine, 4'b0000};
  assign busy  = oip;

  snf_busy_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .load  (busy_cycles),
    .busy  (oip),
    .done  (done)
  );

  snf_status_flags u_flags (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .start_op    (start_op),
    .wren        (do_wren),
    .wrdi        (do_wrdi),
    .done        (done),
    .op_fail     (op_fail),
    .ecc_en      (cfg[CFG_ECC_BIT]),
    .ecc_in      (ecc_result),
    .ecc_fine_in (ecc_detail),
    .wel         (wel),
    .p_fail      (p_fail),
    .e_fail      (e_fail),
    .ecc         (ecc),
    .ecc_fine    (ecc_fine)
  );

  snf_feature_regs u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (do_set),
    .rd_en   (is_get),
    .addr    (feat_addr),
    .wdata   (feat_wdata),
    .stat0   (stat0),
    .stat1   (stat1),
    .prot    (prot),
    .cfg     (cfg),
    .rd_data (rd_data)
  );

  // R5: program or erase without the latch never raises busy
  p_wel_gate_r5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !busy && !wel && (op_code == OPC_PEXEC || op_code == OPC_ERASE))
    |=> !busy);
  // R7: latch commands ignored while busy
  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && busy && !done && (op_code == OPC_WREN || op_code == OPC_WRDI))
    |=> (wel == $past(wel)));
  // R7: configuration writes ignored while busy
  p_busy_noset_r7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && busy && op_code == OPC_SET) |=> $stable(cfg) && $stable(prot));
  // R6: an accepted start raises busy next cycle
  p_start_busy_r6: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);
endmodule

// File: tb/snf_status_model_tb.sv
module snf_status_model_tb;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_valid = 1'b0;
  logic [7:0] op_code = 8'h00, feat_addr = 8'h00, feat_wdata = 8'h00;
  logic [CNT_W-1:0] busy_cycles = '0;
  logic op_fail = 1'b0;
  logic [1:0] ecc_result = 2'b00, ecc_detail = 2'b00;
  logic [7:0] rd_data;
  logic busy;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  snf_status_model #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .feat_addr(feat_addr), .feat_wdata(feat_wdata), .busy_cycles(busy_cycles),
    .op_fail(op_fail), .ecc_result(ecc_result), .ecc_detail(ecc_detail),
    .rd_data(rd_data), .busy(busy)
  );

  // behavioural reference model
  bit m_oip, m_wel, m_pf, m_ef;
  int m_cnt, m_kind;               // kind: 0 none, 1 prog, 2 erase, 3 read, 4 reset
  bit [1:0] m_ecc, m_fine;
  bit [7:0] m_prot, m_cfg, m_rd;

  function automatic bit [7:0] m_read(input bit [7:0] a);
    case (a)
      8'hA0: return m_prot;
      8'hB0: return m_cfg;
      8'hC0: return {2'b00, m_ecc, m_pf, m_ef, m_wel, m_oip};
      8'hF0: return {2'b00, m_fine, 4'b0000};
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_oip = 0; m_wel = 0; m_pf = 0; m_ef = 0; m_cnt = 0; m_kind = 0;
      m_ecc = 0; m_fine = 0; m_prot = 0; m_cfg = 0; m_rd = 0;
    end else begin
      bit was_busy;
      was_busy = m_oip;
      if (op_valid && op_code == 8'h0F) m_rd = m_read(feat_addr);
      if (m_oip && m_cnt == 1) begin
        if (m_kind == 1) begin m_pf = op_fail; m_wel = 0; end
        if (m_kind == 2) begin m_ef = op_fail; m_wel = 0; end
        if (m_kind == 3) begin
          if (m_cfg[4]) begin
            m_ecc = ecc_result;
            m_fine = (ecc_result == 2'b01) ? ecc_detail : 2'b00;
          end else begin m_ecc = 0; m_fine = 0; end
        end
        m_oip = 0; m_kind = 0; m_cnt = 0;
      end else if (m_oip) m_cnt--;
      if (op_valid && op_code == 8'hFF) begin
        m_wel = 0; m_pf = 0; m_ef = 0; m_ecc = 0; m_fine = 0;
        m_oip = 1; m_kind = 4; m_cnt = (busy_cycles == 0) ? 1 : int'(busy_cycles);
      end else if (op_valid && !was_busy) begin
        case (op_code)
          8'h06: m_wel = 1;
          8'h04: m_wel = 0;
          8'h1F: begin
            if (feat_addr == 8'hA0) m_prot = feat_wdata & 8'hFE;
            if (feat_addr == 8'hB0) m_cfg  = feat_wdata & 8'h11;
          end
          8'h10, 8'hD8, 8'h13: begin
            if (op_code == 8'h13 || m_wel) begin
              if (op_code == 8'h10) begin m_pf = 0; m_kind = 1; end
              if (op_code == 8'hD8) begin m_ef = 0; m_kind = 2; end
              if (op_code == 8'h13) m_kind = 3;
              m_oip = 1; m_cnt = (busy_cycles == 0) ? 1 : int'(busy_cycles);
            end
          end
          default: ;
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison with the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(busy == m_oip, "R6 busy vs model", busy, m_oip);
      check(rd_data == m_rd, "R2 rd_data vs model", rd_data, m_rd);
    end
  end

  task automatic cmd(input bit [7:0] op, input bit [7:0] a = 8'h00, input bit [7:0] d = 8'h00);
    op_valid = 1'b1; op_code = op; feat_addr = a; feat_wdata = d;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic rd_check(input bit [7:0] a, input bit [7:0] exp, input string req);
    cmd(8'h0F, a);
    check(rd_data == exp, req, rd_data, exp);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1 busy after reset", busy, 0);
    check(rd_data == 8'h00, "R1 rd_data after reset", rd_data, 0);
    rd_check(8'hC0, 8'h00, "R1 status after reset");
    rd_check(8'hA0, 8'h00, "R1 protection after reset");

    // R3 feature writes
    cmd(8'h1F, 8'hA0, 8'hFF); rd_check(8'hA0, 8'hFE, "R3 protection write");
    cmd(8'h1F, 8'hB0, 8'hFF); rd_check(8'hB0, 8'h11, "R3 config write");
    cmd(8'h1F, 8'hC0, 8'hFF); rd_check(8'hC0, 8'h00, "R3 status write ignored");
    cmd(8'h1F, 8'hF0, 8'hFF); rd_check(8'hF0, 8'h00, "R3 status2 write ignored");
    rd_check(8'h55, 8'h00, "R2 unmapped address");

    // R5 program/erase without latch
    busy_cycles = 4;
    cmd(8'h10); check(busy == 1'b0, "R5 program w/o latch", busy, 0);
    cmd(8'hD8); check(busy == 1'b0, "R5 erase w/o latch", busy, 0);
    rd_check(8'hC0, 8'h00, "R5 flags unchanged");

    // R4 latch
    cmd(8'h06); rd_check(8'hC0, 8'h02, "R4 write enable");
    cmd(8'h04); rd_check(8'hC0, 8'h00, "R4 write disable");

    // R8 program with fail, R6 duration
    cmd(8'h06); busy_cycles = 5; op_fail = 1'b1;
    cmd(8'h10); count_busy(n); check(n == 5, "R6 program busy length", n, 5);
    rd_check(8'hC0, 8'h08, "R8 program fail set, latch cleared");
    cmd(8'h06); busy_cycles = 3; op_fail = 1'b0;
    cmd(8'h10); rd_check(8'hC0, 8'h03, "R8 program fail cleared at start");
    wait_idle(); rd_check(8'hC0, 8'h00, "R8 program pass");

    // R9 erase
    cmd(8'h06); busy_cycles = 4; op_fail = 1'b1;
    cmd(8'hD8); wait_idle(); rd_check(8'hC0, 8'h04, "R9 erase fail set");
    cmd(8'h06); op_fail = 1'b0;
    cmd(8'hD8); rd_check(8'hC0, 8'h03, "R9 erase fail cleared at start");
    wait_idle(); rd_check(8'hC0, 8'h00, "R9 erase pass");

    // R7 ignored while busy
    busy_cycles = 6; ecc_result = 2'b00;
    cmd(8'h13);
    cmd(8'h06); cmd(8'h1F, 8'hB0, 8'h00); cmd(8'h10);
    check(busy == 1'b1, "R7 still busy", busy, 1);
    wait_idle();
    rd_check(8'hC0, 8'h00, "R7 latch not set while busy");
    rd_check(8'hB0, 8'h11, "R7 config not written while busy");

    // R10 ECC capture
    busy_cycles = 2; ecc_result = 2'b01; ecc_detail = 2'b10;
    cmd(8'h13); wait_idle();
    rd_check(8'hC0, 8'h10, "R10 corrected outcome");
    rd_check(8'hF0, 8'h20, "R10 detail captured");
    ecc_result = 2'b11; ecc_detail = 2'b11;
    cmd(8'h13); wait_idle();
    rd_check(8'hC0, 8'h30, "R10 limit outcome");
    rd_check(8'hF0, 8'h00, "R10 detail dropped");
    cmd(8'h1F, 8'hB0, 8'h01); ecc_result = 2'b10;
    cmd(8'h13); wait_idle();
    rd_check(8'hC0, 8'h00, "R10 ECC disabled");
    cmd(8'h1F, 8'hB0, 8'h10);

    // R11 reset aborts
    ecc_result = 2'b01; ecc_detail = 2'b01;
    cmd(8'h13); wait_idle();
    cmd(8'h06); op_fail = 1'b1; busy_cycles = 3;
    cmd(8'h10); wait_idle();
    rd_check(8'hC0, 8'h18, "R11 setup flags");
    cmd(8'h06); busy_cycles = 20;
    cmd(8'hD8); repeat (3) @(negedge clk);
    busy_cycles = 3;
    cmd(8'hFF); count_busy(n); check(n == 3, "R11 reset busy length", n, 3);
    rd_check(8'hC0, 8'h00, "R11 flags cleared, erase abandoned");
    rd_check(8'hF0, 8'h00, "R11 detail cleared");
    rd_check(8'hA0, 8'hFE, "R11 protection kept");
    op_fail = 1'b0;

    // R6 zero duration
    busy_cycles = 0;
    cmd(8'h13); count_busy(n); check(n == 1, "R6 zero count gives one cycle", n, 1);

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule